// File: doc/BRIEF.md
# Timing Recovery Loop Filter and Oscillator

This block closes the timing recovery loop of a symbol-synchronizing receiver. It accepts one signed timing-error value per symbol, tagged by a valid pulse. It smooths that value through a proportional-plus-integral filter, and the filter result sets the step size of a numerically controlled oscillator. The oscillator is clocked at the fixed input sample rate and tells a downstream interpolator two things: when to compute an output sample, and where that sample lies between two input samples.

The oscillator keeps a phase register that is lowered by the control word on every input clock. A borrow out of that register is an interpolation strobe. The strobe tells the interpolator to take the current input sample as its base point. At each strobe the residual phase is divided by the control word, which gives the fractional interval. Strobes are tagged in turn as a mid-symbol point and an on-time point, so the error detector upstream knows which samples to combine.

When the loop is locked, strobes come at twice the symbol rate and the filter output stays constant. The gains and the nominal step are inputs. Choosing them from a bandwidth and damping target is done outside this block.

Top module: `timing_loop_nco`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears the integral path and the filtered output, drives `strobe` and `mu` to 0, sets `sym_tag` to 1, and loads `ctrl_word` with `base_freq`.
- R2: When `err_valid` is low at a clock edge, `filt_out` and the integral state keep their values, whatever `err_in`, `kp` and `ki` are.
- R3: When `err_valid` is high at a clock edge, the integral becomes integral + floor(`err_in`·`ki` / 2^I_SHIFT). At the same edge, `filt_out` becomes floor(`err_in`·`kp` / 2^P_SHIFT) + the new integral. `err_in` is signed two's complement; `kp` and `ki` are unsigned.
- R4: The integral is a signed INT_W-bit value that clamps at +2^(INT_W-1)−1 and −2^(INT_W-1) and never wraps around.
- R5: `ctrl_word` equals `base_freq` + `filt_out`·2^SENS_SHIFT (modulo 2^CTRL_W), using the `filt_out` and `base_freq` values present one clock earlier.
- R6: The phase register resets to all ones and is lowered by `ctrl_word` on every clock. `strobe` is high for the one cycle after an edge at which the phase was below `ctrl_word`. With `ctrl_word` = 2^30 and no error input, strobes repeat every 4 clocks, and the first one follows the 4th edge after reset.
- R7: At each strobe, `mu` is loaded with floor(phase·2^FRAC_W / `ctrl_word`), where phase is the value just before the wrap. `mu` holds its value between strobes.
- R8: `sym_tag` toggles at every strobe. The first strobe after reset carries 0 (mid-symbol point) and the next carries 1 (on-time point).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| err_in | input | ERR_W | Signed per-symbol timing error |
| err_valid | input | 1 | Qualifies `err_in` for one clock |
| kp | input | GAIN_W | Proportional gain, unsigned |
| ki | input | GAIN_W | Integral gain, unsigned |
| base_freq | input | CTRL_W | Nominal oscillator step |
| strobe | output | 1 | Interpolation strobe; the current input sample is the base point |
| mu | output | FRAC_W | Fractional interval, an unsigned fraction of one sample |
| sym_tag | output | 1 | 0 = mid-symbol strobe, 1 = on-time strobe |
| filt_out | output | FILT_W | Signed filtered control value |
| ctrl_word | output | CTRL_W | Oscillator step in use |

## Verification
The bench builds the block with its default parameters: 16-bit error and gains, shifts of 8 for both gains, 4 for sensitivity, a 24-bit integral and an 8-bit fraction. With these values, an error of full scale multiplied by a gain of full scale adds about 2^23 per symbol. The integral therefore reaches either clamp within two or three valid pulses. With a nominal step of 2^30 the strobe period is four clocks, so the reset phase, the first wrap, a fraction of 255 and tag alternation can all be seen within a few cycles. Mixed-sign error patterns then move the step off a power of two, so `mu` takes non-trivial values.

// File: rtl/tl_pkg.sv
// Package shared by the timing loop blocks: the strobe tag type and the
// default sizes. It assumes nothing beyond plain SystemVerilog types.
package tl_pkg;
    typedef enum logic {
        TAG_MID    = 1'b0,
        TAG_ONTIME = 1'b1
    } tl_tag_e;

    localparam int unsigned DEF_PH_W   = 32;
    localparam int unsigned DEF_FRAC_W = 8;
endpackage

// File: rtl/tl_loop_filter.sv
// Proportional-plus-integral loop filter and control word register.
// Assumes err_in is signed and gains are unsigned; the integral clamps.
module tl_loop_filter #(
    parameter int unsigned ERR_W      = 16,
    parameter int unsigned GAIN_W     = 16,
    parameter int unsigned INT_W      = 24,
    parameter int unsigned FILT_W     = 26,
    parameter int unsigned CTRL_W     = 32,
    parameter int unsigned P_SHIFT    = 8,
    parameter int unsigned I_SHIFT    = 8,
    parameter int unsigned SENS_SHIFT = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [ERR_W-1:0]  err_in,
    input  logic                     err_valid,
    input  logic [GAIN_W-1:0]        kp,
    input  logic [GAIN_W-1:0]        ki,
    input  logic [CTRL_W-1:0]        base_freq,
    output logic signed [FILT_W-1:0] filt_o,
    output logic signed [INT_W-1:0]  integ_o,
    output logic [CTRL_W-1:0]        ctrl_o
);
    localparam int unsigned PROD_W = ERR_W + GAIN_W + 1;
    localparam int unsigned SUM_W  = PROD_W + 1;
    localparam logic signed [SUM_W-1:0] INT_MAX =
        SUM_W'((64'sd1 <<< (INT_W - 1)) - 64'sd1);
    localparam logic signed [SUM_W-1:0] INT_MIN = -INT_MAX - 1;

    logic signed [PROD_W-1:0] err_x, kp_x, ki_x;
    logic signed [PROD_W-1:0] prod_p, prod_i;
    logic signed [SUM_W-1:0]  integ_sum, filt_sum;
    logic signed [INT_W-1:0]  integ_q, integ_nx;
    logic signed [FILT_W-1:0] filt_q;
    logic [CTRL_W-1:0]        ctrl_q;

    // Widen operands so the products keep full precision and sign.
    always_comb begin
        err_x  = PROD_W'(err_in);
        kp_x   = $signed(PROD_W'({1'b0, kp}));
        ki_x   = $signed(PROD_W'({1'b0, ki}));
        prod_p = err_x * kp_x;
        prod_i = err_x * ki_x;
    end

    // Next integral: add the scaled increment, then clamp to INT_W bits.
    always_comb begin
        integ_sum = SUM_W'(integ_q) + SUM_W'(prod_i >>> I_SHIFT);
        if (integ_sum > INT_MAX)
            integ_nx = INT_W'(INT_MAX);
        else if (integ_sum < INT_MIN)
            integ_nx = INT_W'(INT_MIN);
        else
            integ_nx = INT_W'(integ_sum);
        filt_sum = SUM_W'(prod_p >>> P_SHIFT) + SUM_W'(integ_nx);
    end

    // Filter state: advances only on a valid error sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            integ_q <= '0;
            filt_q  <= '0;
        end else if (err_valid) begin
            integ_q <= integ_nx;
            filt_q  <= FILT_W'(filt_sum);
        end
    end

    // Control word: nominal step plus the scaled filter output.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= base_freq;
        else
            ctrl_q <= base_freq + (CTRL_W'(filt_q) << SENS_SHIFT);
    end

    assign filt_o  = filt_q;
    assign integ_o = integ_q;
    assign ctrl_o  = ctrl_q;
endmodule

// File: rtl/tl_frac_div.sv
// Unrolled restoring divider giving the FRAC_W-bit fraction num/den.
// Assumes num < den; the result is meaningless otherwise.
module tl_frac_div #(
    parameter int unsigned PH_W   = 32,
    parameter int unsigned FRAC_W = 8
) (
    input  logic [PH_W-1:0]   num,
    input  logic [PH_W-1:0]   den,
    output logic [FRAC_W-1:0] quo
);
    logic [PH_W-1:0] rem [FRAC_W];

    assign rem[0] = num;

    // One quotient bit per stage, most significant bit first.
    for (genvar i = 0; i < FRAC_W; i++) begin : g_stage
        logic [PH_W:0] sh;
        logic          ge;
        assign sh = {rem[i], 1'b0};
        assign ge = (sh >= {1'b0, den});
        assign quo[FRAC_W-1-i] = ge;
        if (i < FRAC_W - 1) begin : g_next
            assign rem[i+1] = PH_W'(ge ? (sh - {1'b0, den}) : sh);
        end
    end
endmodule

// File: rtl/tl_nco.sv
// Down-counting phase oscillator. A borrow is a strobe; it registers the
// fraction and flips the tag. Assumes step is nonzero in normal use.
module tl_nco
    import tl_pkg::*;
#(
    parameter int unsigned PH_W   = DEF_PH_W,
    parameter int unsigned FRAC_W = DEF_FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PH_W-1:0]   step,
    output logic              strobe,
    output logic [FRAC_W-1:0] mu,
    output logic              sym_tag
);
    logic [PH_W-1:0]   phase_q;
    logic [FRAC_W-1:0] mu_q, frac_w;
    logic              strobe_q, wrap;
    tl_tag_e           tag_q;

    assign wrap = (phase_q < step);

    tl_frac_div #(.PH_W(PH_W), .FRAC_W(FRAC_W)) u_div (
        .num (phase_q),
        .den (step),
        .quo (frac_w)
    );

    // Phase, strobe, fraction and tag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= '1;
            strobe_q <= 1'b0;
            mu_q     <= '0;
            tag_q    <= TAG_ONTIME;
        end else begin
            phase_q  <= phase_q - step;
            strobe_q <= wrap;
            if (wrap) begin
                mu_q  <= frac_w;
                tag_q <= (tag_q == TAG_MID) ? TAG_ONTIME : TAG_MID;
            end
        end
    end

    assign strobe  = strobe_q;
    assign mu      = mu_q;
    assign sym_tag = tag_q;
endmodule

// File: rtl/timing_loop_nco.sv
// Top of the timing loop: loop filter feeding the strobe oscillator.
// Assumes one error sample per symbol and a nominal step near twice the
// symbol rate relative to the sample clock.
module timing_loop_nco #(
    parameter int unsigned ERR_W      = 16,
    parameter int unsigned GAIN_W     = 16,
    parameter int unsigned INT_W      = 24,
    parameter int unsigned FILT_W     = INT_W + 2,
    parameter int unsigned CTRL_W     = 32,
    parameter int unsigned FRAC_W     = 8,
    parameter int unsigned P_SHIFT    = 8,
    parameter int unsigned I_SHIFT    = 8,
    parameter int unsigned SENS_SHIFT = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [ERR_W-1:0]  err_in,
    input  logic                     err_valid,
    input  logic [GAIN_W-1:0]        kp,
    input  logic [GAIN_W-1:0]        ki,
    input  logic [CTRL_W-1:0]        base_freq,
    output logic                     strobe,
    output logic [FRAC_W-1:0]        mu,
    output logic                     sym_tag,
    output logic signed [FILT_W-1:0] filt_out,
    output logic [CTRL_W-1:0]        ctrl_word
);
    logic signed [INT_W-1:0] integ_w;

    tl_loop_filter #(
        .ERR_W(ERR_W), .GAIN_W(GAIN_W), .INT_W(INT_W), .FILT_W(FILT_W),
        .CTRL_W(CTRL_W), .P_SHIFT(P_SHIFT), .I_SHIFT(I_SHIFT),
        .SENS_SHIFT(SENS_SHIFT)
    ) u_lf (
        .clk       (clk),
        .rst_n     (rst_n),
        .err_in    (err_in),
        .err_valid (err_valid),
        .kp        (kp),
        .ki        (ki),
        .base_freq (base_freq),
        .filt_o    (filt_out),
        .integ_o   (integ_w),
        .ctrl_o    (ctrl_word)
    );

    tl_nco #(.PH_W(CTRL_W), .FRAC_W(FRAC_W)) u_nco (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (ctrl_word),
        .strobe  (strobe),
        .mu      (mu),
        .sym_tag (sym_tag)
    );
endmodule

// File: rtl/tl_checker.sv
// Temporal checks on the timing loop, attached to the top by bind.
module tl_checker #(
    parameter int unsigned INT_W      = 24,
    parameter int unsigned FILT_W     = 26,
    parameter int unsigned CTRL_W     = 32,
    parameter int unsigned FRAC_W     = 8,
    parameter int unsigned SENS_SHIFT = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     err_valid,
    input logic                     err_msb,
    input logic                     strobe,
    input logic                     sym_tag,
    input logic [FRAC_W-1:0]        mu,
    input logic signed [FILT_W-1:0] filt,
    input logic signed [INT_W-1:0]  integ,
    input logic [CTRL_W-1:0]        ctrl_word,
    input logic [CTRL_W-1:0]        base_freq
);
    localparam logic signed [INT_W-1:0] IMAX = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic signed [INT_W-1:0] IMIN = {1'b1, {(INT_W-1){1'b0}}};

    logic [CTRL_W-1:0] filt_scaled;
    logic              seen_q, last_tag_q;

    assign filt_scaled = CTRL_W'(filt) << SENS_SHIFT;

    // Remember the tag of the previous strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q     <= 1'b0;
            last_tag_q <= 1'b0;
        end else if (strobe) begin
            seen_q     <= 1'b1;
            last_tag_q <= sym_tag;
        end
    end

    AST_FILT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !err_valid |=> $stable(filt) && $stable(integ)); // R2
    AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (integ == IMAX && err_valid && !err_msb) |=> integ == IMAX); // R4
    AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (integ == IMIN && err_valid && err_msb) |=> integ == IMIN); // R4
    AST_CTRL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ctrl_word == $past(base_freq) + $past(filt_scaled)); // R5
    AST_MU_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |-> $stable(mu)); // R7
    AST_TAG_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !seen_q) |-> sym_tag == 1'b0); // R8
    AST_TAG_ALT: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && seen_q) |-> sym_tag != last_tag_q); // R8
endmodule

bind timing_loop_nco tl_checker #(
    .INT_W(INT_W), .FILT_W(FILT_W), .CTRL_W(CTRL_W), .FRAC_W(FRAC_W),
    .SENS_SHIFT(SENS_SHIFT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .err_valid (err_valid),
    .err_msb   (err_in[ERR_W-1]),
    .strobe    (strobe),
    .sym_tag   (sym_tag),
    .mu        (mu),
    .filt      (filt_out),
    .integ     (integ_w),
    .ctrl_word (ctrl_word),
    .base_freq (base_freq)
);

// File: tb/timing_loop_nco_test.sv
`timescale 1ns/1ps
// Bench: a stimulus table walked by one loop, then directed reset,
// hold and saturation tests. A behavioural model gives expected values.
module timing_loop_nco_test;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic signed [15:0] err_in = '0;
    logic               err_valid = 1'b0;
    logic [15:0]        kp = '0;
    logic [15:0]        ki = '0;
    logic [31:0]        base_freq = 32'h4000_0000;
    logic               strobe;
    logic [7:0]         mu;
    logic               sym_tag;
    logic signed [25:0] filt_out;
    logic [31:0]        ctrl_word;

    int n_checks = 0;
    int n_fails  = 0;

    // Model state
    longint      m_integ, m_filt;
    logic [31:0] m_ctrl, m_phase;
    logic        m_strobe, m_tag;
    logic [7:0]  m_mu;

    // Stimulus: {err, valid, kp, ki}
    localparam logic [48:0] VEC [12] = '{
        {16'sd1000,   1'b1, 16'd256,  16'd16},
        {16'sd0,      1'b0, 16'd256,  16'd16},
        {-16'sd2000,  1'b1, 16'd512,  16'd64},
        {16'sd500,    1'b1, 16'd1000, 16'd100},
        {16'sd9999,   1'b0, 16'd999,  16'd999},
        {16'sd0,      1'b0, 16'd0,    16'd0},
        {-16'sd300,   1'b1, 16'd2000, 16'd300},
        {16'sd12000,  1'b1, 16'd4000, 16'd8},
        {16'sd0,      1'b0, 16'd0,    16'd0},
        {-16'sd7000,  1'b1, 16'd100,  16'd200},
        {16'sd0,      1'b0, 16'd0,    16'd0},
        {16'sd0,      1'b0, 16'd0,    16'd0}
    };

    always #4 clk = ~clk;

    timing_loop_nco uut (
        .clk(clk), .rst_n(rst_n), .err_in(err_in), .err_valid(err_valid),
        .kp(kp), .ki(ki), .base_freq(base_freq), .strobe(strobe), .mu(mu),
        .sym_tag(sym_tag), .filt_out(filt_out), .ctrl_word(ctrl_word)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Advance the model and the design by one clock, then compare all outputs.
    task automatic step();
        longint n_integ, n_filt;
        logic [31:0] n_ctrl;
        n_integ = m_integ;
        n_filt  = m_filt;
        if (err_valid) begin
            n_integ = m_integ + ((longint'(err_in) * longint'(ki)) >>> 8);
            if (n_integ > 64'sd8388607)  n_integ = 64'sd8388607;
            if (n_integ < -64'sd8388608) n_integ = -64'sd8388608;
            n_filt = ((longint'(err_in) * longint'(kp)) >>> 8) + n_integ;
        end
        n_ctrl = 32'(longint'(base_freq) + m_filt * 16);
        m_strobe = (m_phase < m_ctrl);
        if (m_strobe) begin
            m_mu  = 8'((longint'(m_phase) * 256) / longint'(m_ctrl));
            m_tag = ~m_tag;
        end
        m_phase = m_phase - m_ctrl;
        m_integ = n_integ;
        m_filt  = n_filt;
        m_ctrl  = n_ctrl;
        @(posedge clk);
        @(negedge clk);
        check(filt_out == m_filt, "R3", "filt_out", filt_out, m_filt);
        check(ctrl_word == m_ctrl, "R5", "ctrl_word", ctrl_word, m_ctrl);
        check(strobe == m_strobe, "R6", "strobe", strobe, m_strobe);
        check(mu == m_mu, "R7", "mu", mu, m_mu);
        check(sym_tag == m_tag, "R8", "sym_tag", sym_tag, m_tag);
    endtask

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        #(100000 * 8);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        // R1: reset values
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(strobe == 1'b0, "R1", "strobe", strobe, 0);
        check(mu == 8'd0, "R1", "mu", mu, 0);
        check(filt_out == 0, "R1", "filt_out", filt_out, 0);
        check(sym_tag == 1'b1, "R1", "sym_tag", sym_tag, 1);
        check(ctrl_word == base_freq, "R1", "ctrl_word", ctrl_word, base_freq);
        m_integ = 0; m_filt = 0; m_ctrl = base_freq; m_phase = '1;
        m_strobe = 1'b0; m_tag = 1'b1; m_mu = '0;
        rst_n = 1'b1;

        // R6/R7/R8: idle run, first strobe after the 4th edge, mu = 255
        for (int i = 0; i < 3; i++) step();
        check(strobe == 1'b0, "R6", "strobe before first wrap", strobe, 0);
        step();
        check(strobe == 1'b1, "R6", "first strobe", strobe, 1);
        check(mu == 8'd255, "R7", "first mu", mu, 255);
        check(sym_tag == 1'b0, "R8", "first tag", sym_tag, 0);
        for (int i = 0; i < 4; i++) step();
        check(sym_tag == 1'b1, "R8", "second tag", sym_tag, 1);

        // Table walk: R3, R5, R6, R7 under mixed error patterns
        for (int i = 0; i < 12; i++) begin
            {err_in, err_valid, kp, ki} = VEC[i];
            step();
        end
        err_valid = 1'b0;
        for (int i = 0; i < 20; i++) step();

        // R2: large error and gains with valid low leave the filter untouched
        begin
            longint held;
            held = filt_out;
            err_in = 16'sd20000; kp = 16'd60000; ki = 16'd60000; err_valid = 1'b0;
            for (int i = 0; i < 5; i++) step();
            check(filt_out == held, "R2", "filt_out held", filt_out, held);
        end

        // R4: positive clamp
        err_in = 16'sd32767; kp = 16'd0; ki = 16'd65535; err_valid = 1'b1;
        for (int i = 0; i < 4; i++) step();
        check(filt_out == 26'sd8388607, "R4", "integral high clamp", filt_out, 8388607);
        // R4: negative clamp
        err_in = -16'sd32768;
        for (int i = 0; i < 5; i++) step();
        check(filt_out == -26'sd8388608, "R4", "integral low clamp", filt_out, -8388608);
        // Release and let the loop settle back
        err_valid = 1'b0; err_in = '0; ki = '0;
        for (int i = 0; i < 10; i++) step();

        // R1: reset mid-run restores nominal step and clears the filter
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(filt_out == 0, "R1", "filt_out after reset", filt_out, 0);
        check(ctrl_word == base_freq, "R1", "ctrl_word after reset", ctrl_word, base_freq);
        check(strobe == 1'b0, "R1", "strobe after reset", strobe, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule